// File: doc/BRIEF.md
# Transport Packet Timestamp Capture

This block receives transport stream packets one byte per clock from a parallel source and marks each packet with the value of a local system time clock. The clock runs on the 27 MHz domain as a split counter: a 9-bit extension that counts 0 to 299, and a 33-bit base that advances once per extension wrap. Software seeds the counter from the reference field of the first packet that carries one, after which the counter tracks the stream.

A packet begins when the start strobe coincides with the capture enable. The counter value in that cycle becomes the packet's 64-bit timestamp, laid out most significant byte first. Bytes are forwarded one cycle after capture. The timestamp is released together with the 188th byte. A packet cut short by a new start strobe is flagged and gets no timestamp release. Two interrupt outputs complete the block. One pulses when the counter enters a value matching a compare word under a mask. The other pulses at a programmable interval of clock cycles.

Top module: `ts_stamp_capture`

## Requirements
- R1: After reset the counter, all interrupt outputs and all stream outputs are 0.
- R2: With no load, the extension advances by one per clock through 0..299; from 299 it returns to 0 and the base advances by one.
- R3: The base wraps from 2^33-1 to 0.
- R4: A load pulse writes the base and extension inputs into the counter at that clock edge, overriding the increment. An extension above 299 is stored as 299. The load also restarts the tick interval.
- R5: A compare interrupt is raised for one cycle, in the cycle after the counter first shows a value whose unmasked bits equal the compare word. A mask bit of 1 excludes that bit. A match that persists gives no further pulse.
- R6: The tick interrupt pulses N cycles after a load and every N cycles after that, where N is the ticks input. N = 0 gives no pulses.
- R7: A packet start is accepted only when the start strobe and the enable are both high. The next cycle shows the start-of-packet flag and the first byte, and the timestamp is taken from the counter value shown in the accepting cycle.
- R8: The timestamp layout is: bits 63:31 hold the base, bits 30:25 are zero, bits 24:16 hold the extension, and bits 15:0 are zero. This places the most significant reference byte in bits 63:56.
- R9: Bytes are accepted only while a packet is open and the enable is high. Each accepted byte appears on the byte output with its valid flag one cycle later. A byte with the enable low, or a byte outside a packet, produces no valid output.
- R10: The 188th accepted byte of a packet is output together with end-of-packet and timestamp-valid. The packet then closes.
- R11: A start accepted while a packet is still open drops the partial packet. That partial packet never shows end-of-packet or timestamp-valid. The drop flag pulses together with the new start-of-packet, and a start from idle does not raise the drop flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 27 MHz capture and counter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Parallel stream byte |
| pstart_i | input | 1 | Packet start strobe, marks the sync byte |
| cap_en_i | input | 1 | Byte qualifier |
| ld_i | input | 1 | Counter load pulse |
| ld_base_i | input | 33 | Base value to load |
| ld_ext_i | input | 9 | Extension value to load |
| cmp_base_i | input | 33 | Compare word, base part |
| cmp_ext_i | input | 9 | Compare word, extension part |
| mask_base_i | input | 33 | Compare mask, base part (1 = ignore) |
| mask_ext_i | input | 9 | Compare mask, extension part (1 = ignore) |
| ticks_i | input | 32 | Tick interval in clock cycles, 0 disables |
| byte_o | output | 8 | Forwarded byte |
| byte_vld_o | output | 1 | Forwarded byte is valid |
| sop_o | output | 1 | Forwarded byte is the packet's first |
| eop_o | output | 1 | Forwarded byte is the packet's 188th |
| stamp_o | output | 64 | Packet timestamp |
| stamp_vld_o | output | 1 | Timestamp belongs to a completed packet |
| drop_o | output | 1 | Partial packet was dropped |
| stc_base_o | output | 33 | Counter base |
| stc_ext_o | output | 9 | Counter extension |
| cmp_irq_o | output | 1 | Compare-match interrupt pulse |
| tick_irq_o | output | 1 | Periodic tick interrupt pulse |

## Verification
On every cycle, the assertions check the following properties. The extension stays below 300 and steps by one. The base holds between wraps. Both interrupts are single-cycle pulses. The packet byte count never passes 188. A drop always coincides with a new start, and a closed packet is followed only by a new start. The bench scenarios cover what depends on chosen values and exact cycles: the wrap of the extension and the base, load priority and clamping, the cycle of a masked compare match, the tick period, the timestamp value and layout, and packet truncation.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int BASE_W  = 33;
  localparam int EXT_W   = 9;
  localparam int EXT_MOD = 300;
  localparam int RSV_W   = 6;
  localparam int STAMP_W = 64;
  localparam int PAD_W   = STAMP_W - BASE_W - RSV_W - EXT_W;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [EXT_W-1:0]  ext;
  } stc_t;

  // most significant reference byte lands in the top byte
  function automatic logic [STAMP_W-1:0] mk_stamp(stc_t s);
    return {s.base, {RSV_W{1'b0}}, s.ext, {PAD_W{1'b0}}};
  endfunction
endpackage

// File: rtl/tsc_stc_counter.sv
module tsc_stc_counter
  import tsc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_i,
  input  stc_t ld_val_i,
  output stc_t stc_o
);
  stc_t             stc_q;
  logic [EXT_W-1:0] ld_ext_c;
  logic             wrap_c;

  assign ld_ext_c = (ld_val_i.ext >= EXT_W'(EXT_MOD)) ? EXT_W'(EXT_MOD - 1) : ld_val_i.ext;
  assign wrap_c   = (stc_q.ext == EXT_W'(EXT_MOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stc_q <= '0;
    end else if (ld_i) begin
      stc_q.base <= ld_val_i.base;
      stc_q.ext  <= ld_ext_c;
    end else if (wrap_c) begin
      stc_q.ext  <= '0;
      stc_q.base <= stc_q.base + BASE_W'(1);
    end else begin
      stc_q.ext  <= stc_q.ext + EXT_W'(1);
    end
  end

  assign stc_o = stc_q;

  // R2
  ext_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stc_q.ext < EXT_W'(EXT_MOD));
  // R2
  ext_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !wrap_c) |=> (stc_q.ext == $past(stc_q.ext) + EXT_W'(1)));
  // R3
  base_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !wrap_c) |=> $stable(stc_q.base));
endmodule

// File: rtl/tsc_irq_gen.sv
module tsc_irq_gen
  import tsc_pkg::*;
#(
  parameter int TICK_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  stc_t              stc_i,
  input  stc_t              cmp_i,
  input  stc_t              mask_i,
  input  logic              ld_i,
  input  logic [TICK_W-1:0] ticks_i,
  output logic              cmp_irq_o,
  output logic              tick_irq_o
);
  logic              match_c, match_q;
  logic [TICK_W-1:0] tick_cnt_q;

  assign match_c = &(~(stc_i ^ cmp_i) | mask_i);

  // pulse only on entry into a matching value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q   <= 1'b0;
      cmp_irq_o <= 1'b0;
    end else begin
      match_q   <= match_c;
      cmp_irq_o <= match_c & ~match_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_cnt_q <= '0;
      tick_irq_o <= 1'b0;
    end else if (ld_i || ticks_i == '0) begin
      tick_cnt_q <= '0;
      tick_irq_o <= 1'b0;
    end else if (tick_cnt_q >= ticks_i - TICK_W'(1)) begin
      tick_cnt_q <= '0;
      tick_irq_o <= 1'b1;
    end else begin
      tick_cnt_q <= tick_cnt_q + TICK_W'(1);
      tick_irq_o <= 1'b0;
    end
  end

  // R5
  cmp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_irq_o |=> !cmp_irq_o);
  // R6
  tick_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_irq_o && ticks_i > TICK_W'(1)) |=> !tick_irq_o);
endmodule

// File: rtl/tsc_pkt_capture.sv
module tsc_pkt_capture
  import tsc_pkg::*;
#(
  parameter int PKT_LEN = 188,
  parameter int BYTE_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [BYTE_W-1:0]  byte_i,
  input  logic               pstart_i,
  input  logic               cap_en_i,
  input  stc_t               stc_i,
  output logic [BYTE_W-1:0]  byte_o,
  output logic               byte_vld_o,
  output logic               sop_o,
  output logic               eop_o,
  output logic [STAMP_W-1:0] stamp_o,
  output logic               stamp_vld_o,
  output logic               drop_o
);
  localparam int CNT_W = $clog2(PKT_LEN + 1);

  logic             in_pkt_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start_c, take_c, last_c;

  assign start_c = cap_en_i & pstart_i;
  assign take_c  = cap_en_i & ~pstart_i & in_pkt_q;
  assign last_c  = (cnt_q == CNT_W'(PKT_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_pkt_q    <= 1'b0;
      cnt_q       <= '0;
      byte_o      <= '0;
      byte_vld_o  <= 1'b0;
      sop_o       <= 1'b0;
      eop_o       <= 1'b0;
      stamp_o     <= '0;
      stamp_vld_o <= 1'b0;
      drop_o      <= 1'b0;
    end else begin
      byte_vld_o  <= 1'b0;
      sop_o       <= 1'b0;
      eop_o       <= 1'b0;
      stamp_vld_o <= 1'b0;
      drop_o      <= 1'b0;
      if (start_c) begin
        in_pkt_q   <= 1'b1;
        cnt_q      <= CNT_W'(1);
        stamp_o    <= mk_stamp(stc_i);
        byte_o     <= byte_i;
        byte_vld_o <= 1'b1;
        sop_o      <= 1'b1;
        drop_o     <= in_pkt_q;
      end else if (take_c) begin
        cnt_q      <= cnt_q + CNT_W'(1);
        byte_o     <= byte_i;
        byte_vld_o <= 1'b1;
        if (last_c) begin
          eop_o       <= 1'b1;
          stamp_vld_o <= 1'b1;
          in_pkt_q    <= 1'b0;
        end
      end
    end
  end

  // R10
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(PKT_LEN));
  // R10
  closed_pkt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |=> (!byte_vld_o || sop_o));
  // R11
  drop_with_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> (sop_o && byte_vld_o));
endmodule

// File: rtl/ts_stamp_capture.sv
module ts_stamp_capture
  import tsc_pkg::*;
#(
  parameter int PKT_LEN = 188,
  parameter int BYTE_W  = 8,
  parameter int TICK_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [BYTE_W-1:0]  byte_i,
  input  logic               pstart_i,
  input  logic               cap_en_i,
  input  logic               ld_i,
  input  logic [BASE_W-1:0]  ld_base_i,
  input  logic [EXT_W-1:0]   ld_ext_i,
  input  logic [BASE_W-1:0]  cmp_base_i,
  input  logic [EXT_W-1:0]   cmp_ext_i,
  input  logic [BASE_W-1:0]  mask_base_i,
  input  logic [EXT_W-1:0]   mask_ext_i,
  input  logic [TICK_W-1:0]  ticks_i,
  output logic [BYTE_W-1:0]  byte_o,
  output logic               byte_vld_o,
  output logic               sop_o,
  output logic               eop_o,
  output logic [STAMP_W-1:0] stamp_o,
  output logic               stamp_vld_o,
  output logic               drop_o,
  output logic [BASE_W-1:0]  stc_base_o,
  output logic [EXT_W-1:0]   stc_ext_o,
  output logic               cmp_irq_o,
  output logic               tick_irq_o
);
  stc_t stc_w, ld_w, cmp_w, mask_w;

  assign ld_w   = '{base: ld_base_i,   ext: ld_ext_i};
  assign cmp_w  = '{base: cmp_base_i,  ext: cmp_ext_i};
  assign mask_w = '{base: mask_base_i, ext: mask_ext_i};

  tsc_stc_counter i_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (ld_i),
    .ld_val_i (ld_w),
    .stc_o    (stc_w)
  );

  tsc_irq_gen #(.TICK_W(TICK_W)) i_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stc_i      (stc_w),
    .cmp_i      (cmp_w),
    .mask_i     (mask_w),
    .ld_i       (ld_i),
    .ticks_i    (ticks_i),
    .cmp_irq_o  (cmp_irq_o),
    .tick_irq_o (tick_irq_o)
  );

  tsc_pkt_capture #(.PKT_LEN(PKT_LEN), .BYTE_W(BYTE_W)) i_capture (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_i      (byte_i),
    .pstart_i    (pstart_i),
    .cap_en_i    (cap_en_i),
    .stc_i       (stc_w),
    .byte_o      (byte_o),
    .byte_vld_o  (byte_vld_o),
    .sop_o       (sop_o),
    .eop_o       (eop_o),
    .stamp_o     (stamp_o),
    .stamp_vld_o (stamp_vld_o),
    .drop_o      (drop_o)
  );

  assign stc_base_o = stc_w.base;
  assign stc_ext_o  = stc_w.ext;
endmodule

// File: tb/test_ts_stamp_capture.sv
module test_ts_stamp_capture;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        pstart_i = 1'b0, cap_en_i = 1'b0, ld_i = 1'b0;
  logic [32:0] ld_base_i = '0, cmp_base_i = 33'h1_0000_0000, mask_base_i = '0;
  logic [8:0]  ld_ext_i = '0, cmp_ext_i = '0, mask_ext_i = '0;
  logic [31:0] ticks_i = '0;
  logic [7:0]  byte_o;
  logic        byte_vld_o, sop_o, eop_o, stamp_vld_o, drop_o, cmp_irq_o, tick_irq_o;
  logic [63:0] stamp_o;
  logic [32:0] stc_base_o;
  logic [8:0]  stc_ext_o;

  int n_chk = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  ts_stamp_capture i_ts_stamp_capture (.*);

  // counter walk vectors: load value, cycles to run, expected value
  localparam logic [32:0] T_LB [6] = '{33'd5, 33'd5, 33'h1_FFFF_FFFF, 33'd0, 33'd9, 33'd123};
  localparam logic [8:0]  T_LE [6] = '{9'd0, 9'd298, 9'd299, 9'd0, 9'd400, 9'd7};
  localparam int          T_N  [6] = '{1, 2, 1, 300, 0, 0};
  localparam logic [32:0] T_EB [6] = '{33'd5, 33'd6, 33'd0, 33'd1, 33'd9, 33'd123};
  localparam logic [8:0]  T_EE [6] = '{9'd1, 9'd0, 9'd0, 9'd0, 9'd299, 9'd7};
  localparam string       T_RQ [6] = '{"R2", "R2", "R3", "R2", "R4", "R4"};

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic load(input logic [32:0] b, input logic [8:0] e);
    ld_i = 1'b1; ld_base_i = b; ld_ext_i = e;
    @(negedge clk_i);
    ld_i = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input logic ps, input logic en);
    byte_i = b; pstart_i = ps; cap_en_i = en;
    @(negedge clk_i);
  endtask

  function automatic logic [63:0] exp_stamp(input logic [32:0] b, input logic [8:0] e);
    return {b, 6'd0, e, 16'd0}; // R8 layout
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] st1, st3;
    int vld_cnt, eop_cnt, sv_cnt;

    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1", "stc", {stc_base_o, stc_ext_o}, '0);
    check("R1", "irqs", {cmp_irq_o, tick_irq_o}, '0);
    check("R1", "stream", {byte_vld_o, sop_o, eop_o, stamp_vld_o, drop_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // counter table walk
    for (int i = 0; i < 6; i++) begin
      load(T_LB[i], T_LE[i]);
      repeat (T_N[i]) @(negedge clk_i);
      check(T_RQ[i], "base", stc_base_o, T_EB[i]);
      check(T_RQ[i], "ext", stc_ext_o, T_EE[i]);
    end

    // R5 exact compare
    cmp_base_i = 33'd0; cmp_ext_i = 9'd5;
    load(33'd0, 9'd0);
    repeat (5) @(negedge clk_i);
    check("R5", "ext before irq", stc_ext_o, 9'd5);
    check("R5", "no irq yet", cmp_irq_o, 1'b0);
    @(negedge clk_i);
    check("R5", "irq", cmp_irq_o, 1'b1);
    @(negedge clk_i);
    check("R5", "irq pulse ends", cmp_irq_o, 1'b0);

    // R5 masked compare: extension ignored
    cmp_base_i = 33'd3; cmp_ext_i = 9'd77; mask_ext_i = 9'h1FF;
    load(33'd2, 9'd299);
    @(negedge clk_i);
    check("R5", "masked pre", cmp_irq_o, 1'b0);
    @(negedge clk_i);
    check("R5", "masked irq", cmp_irq_o, 1'b1);
    @(negedge clk_i);
    check("R5", "persisting match no pulse", cmp_irq_o, 1'b0);
    cmp_base_i = 33'h1_0000_0000; mask_ext_i = '0;

    // R6 tick interval
    ticks_i = 32'd10;
    load(33'd0, 9'd0);
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk_i);
      if (k == 9 || k == 11) check("R6", "tick low", tick_irq_o, 1'b0);
      if (k == 10 || k == 20) check("R6", "tick high", tick_irq_o, 1'b1);
    end
    ticks_i = 32'd0;
    load(33'd0, 9'd0);
    sv_cnt = 0;
    repeat (30) begin @(negedge clk_i); if (tick_irq_o) sv_cnt++; end
    check("R6", "ticks zero disables", sv_cnt, 0);

    // R9 / R7 ignored bytes
    send(8'hAA, 1'b0, 1'b1);
    check("R9", "byte outside packet", byte_vld_o, 1'b0);
    send(8'h47, 1'b1, 1'b0);
    check("R7", "start without enable", {sop_o, byte_vld_o}, '0);

    // packet 1
    st1 = exp_stamp(stc_base_o, stc_ext_o);
    send(8'h47, 1'b1, 1'b1);
    check("R7", "sop", {sop_o, byte_vld_o, byte_o}, {2'b11, 8'h47});
    check("R11", "no drop from idle", drop_o, 1'b0);
    vld_cnt = 1; eop_cnt = 0; sv_cnt = 0;
    for (int i = 1; i < 188; i++) begin
      if (i == 50) begin
        send(8'h55, 1'b0, 1'b0);
        check("R9", "enable low gap", byte_vld_o, 1'b0);
      end
      send(8'(i), 1'b0, 1'b1);
      if (byte_vld_o) vld_cnt++;
      if (eop_o) eop_cnt++;
      if (stamp_vld_o) sv_cnt++;
    end
    check("R10", "last eop", {eop_o, stamp_vld_o}, 2'b11);
    check("R9", "last byte", byte_o, 8'd187);
    check("R10", "byte count", vld_cnt, 188);
    check("R10", "one eop", eop_cnt, 1);
    check("R8", "stamp value", stamp_o, st1);
    send(8'h11, 1'b0, 1'b1);
    check("R10", "closed after 188", byte_vld_o, 1'b0);

    // packet 2 truncated, packet 3 complete
    send(8'h47, 1'b1, 1'b1);
    sv_cnt = 0; eop_cnt = 0;
    for (int i = 1; i < 21; i++) begin
      send(8'(i), 1'b0, 1'b1);
      if (stamp_vld_o) sv_cnt++;
      if (eop_o) eop_cnt++;
    end
    st3 = exp_stamp(stc_base_o, stc_ext_o);
    send(8'h47, 1'b1, 1'b1);
    check("R11", "drop with new sop", {drop_o, sop_o}, 2'b11);
    check("R11", "partial no stamp", sv_cnt + eop_cnt, 0);
    for (int i = 1; i < 188; i++) send(8'(i + 3), 1'b0, 1'b1);
    check("R10", "after drop eop", {eop_o, stamp_vld_o}, 2'b11);
    check("R7", "new stamp", stamp_o, st3);
    cap_en_i = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule